// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block is the hazard logic placed beside the decode stage of a five-stage in-order integer pipeline. For each of the two source register numbers of the instruction in decode, it searches the destination registers held in the execute, memory and write-back stage registers. It then produces a 2-bit select code for the multiplexer that feeds that operand register.

The same select codes decide whether a load-use stall is needed. If the instruction now in execute is a load and either operand would take the execute-stage result, that data does not exist yet. The unit then raises a stall. The surrounding pipeline uses it to hold the program counter and the fetch/decode instruction register, and it writes a bubble into execute. One cycle later the load has moved to the memory stage, and the dependent instruction picks up the loaded value from there.

The unit is purely combinational. Its outputs depend only on the current contents of the stage registers.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An operand select is 0 (register-file value) when no stage holds a valid match for that source register.
- R2: An operand select is 1 when the execute stage has its register-write bit set and its destination equals the source register.
- R3: An operand select is 2 when the memory stage has a valid match and the execute stage does not.
- R4: An operand select is 3 when the write-back stage has a valid match and neither the execute nor the memory stage does.
- R5: When several stages match, the nearest stage wins: execute first, then memory, then write-back.
- R6: A source register number of 0 never forwards. Its select is 0 even if a stage writes register 0.
- R7: A stage whose register-write bit is clear never matches, whatever its destination.
- R8: Operand A is resolved from the first source field and operand B from the second, with the same rules, independently of each other.
- R9: The stall output is 1 exactly when the execute stage's memory-read bit is set and at least one operand select equals 1.
- R10: A load that has already reached the memory or write-back stage causes no stall. Neither does a non-load in execute.
- R11: The pipeline holds fetch and decode for one cycle and puts a bubble into execute. After that, the dependent instruction receives select 2 and no stall.
- R12: Back-to-back dependent loads each cost exactly one stall cycle. No earlier bubble creates a false match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_i | input | REG_AW | First source register number of the instruction in decode |
| src_b_i | input | REG_AW | Second source register number of the instruction in decode |
| ex_dst_i | input | REG_AW | Destination register held by the execute stage |
| ex_wr_en_i | input | 1 | Register-write bit of the execute stage |
| ex_load_i | input | 1 | Memory-read bit of the execute stage |
| mem_dst_i | input | REG_AW | Destination register held by the memory stage |
| mem_wr_en_i | input | 1 | Register-write bit of the memory stage |
| wb_dst_i | input | REG_AW | Destination register held by the write-back stage |
| wb_wr_en_i | input | 1 | Register-write bit of the write-back stage |
| sel_a_o | output | 2 | Operand A source: 0 register file, 1 execute, 2 memory, 3 write-back |
| sel_b_o | output | 2 | Operand B source, same encoding |
| stall_o | output | 1 | Load-use stall: hold PC and instruction register, insert bubble |

## Verification
The checker evaluates several rules whenever an input changes:
- Each select code is consistent with the stage matches: a code names a matching stage, and no nearer stage also matches.
- Register 0 never forwards.
- The stall equals the load-in-execute condition combined with the selects.

Some behaviours appear only over several cycles, in the bench's small pipeline model:
- the select moving from 1 to 2 after the inserted bubble;
- the cost of one stall per dependent load in a chain of loads;
- bubbles never producing matches.

// File: rtl/fwd_hazard_pkg.sv
`timescale 1ns/1ps
package fwd_hazard_pkg;
  localparam int unsigned FWD_STAGES = 3;
  localparam int unsigned SEL_W      = $clog2(FWD_STAGES + 1);

  // code value = distance of the producing instruction ahead of decode
  typedef enum logic [SEL_W-1:0] {
    OPND_RF  = SEL_W'(0),
    OPND_EX  = SEL_W'(1),
    OPND_MEM = SEL_W'(2),
    OPND_WB  = SEL_W'(3)
  } opnd_src_e;
endpackage

// File: rtl/hz_dest_match.sv
`timescale 1ns/1ps
module hz_dest_match #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] dst_i,
  input  logic              wr_en_i,
  output logic              hit_o
);
  logic src_live;
  assign src_live = |src_i;
  assign hit_o    = wr_en_i & src_live & (src_i == dst_i);
endmodule

// File: rtl/hz_prio_sel.sv
`timescale 1ns/1ps
module hz_prio_sel #(
  parameter int unsigned NUM_STAGE = 3,
  parameter int unsigned SEL_W     = 2
) (
  input  logic [NUM_STAGE-1:0] hit_i,
  output logic [SEL_W-1:0]     sel_o
);
  // index 0 is the nearest stage; scan far to near so the nearest wins
  always_comb begin
    sel_o = '0;
    for (int k = NUM_STAGE - 1; k >= 0; k--) begin
      if (hit_i[k]) sel_o = SEL_W'(k + 1);
    end
  end
endmodule

// File: rtl/hz_load_stall.sv
`timescale 1ns/1ps
module hz_load_stall #(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned SEL_W   = 2
) (
  input  logic                          ex_load_i,
  input  logic [NUM_SRC-1:0][SEL_W-1:0] sel_i,
  output logic                          stall_o
);
  logic [NUM_SRC-1:0] wants_ex;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_use
    assign wants_ex[g] = (sel_i[g] == SEL_W'(1));
  end

  assign stall_o = ex_load_i & (|wants_ex);
endmodule

// File: rtl/fwd_hazard_unit.sv
`timescale 1ns/1ps
module fwd_hazard_unit
  import fwd_hazard_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_a_i,
  input  logic [REG_AW-1:0] src_b_i,
  input  logic [REG_AW-1:0] ex_dst_i,
  input  logic              ex_wr_en_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] mem_dst_i,
  input  logic              mem_wr_en_i,
  input  logic [REG_AW-1:0] wb_dst_i,
  input  logic              wb_wr_en_i,
  output logic [SEL_W-1:0]  sel_a_o,
  output logic [SEL_W-1:0]  sel_b_o,
  output logic              stall_o
);
  localparam int unsigned NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_AW-1:0]    src;
  logic [FWD_STAGES-1:0][REG_AW-1:0] dst;
  logic [FWD_STAGES-1:0]             wr_en;
  logic [NUM_SRC-1:0][FWD_STAGES-1:0] hit;
  logic [NUM_SRC-1:0][SEL_W-1:0]     sel;

  assign src   = {src_b_i, src_a_i};
  assign dst   = {wb_dst_i, mem_dst_i, ex_dst_i};
  assign wr_en = {wb_wr_en_i, mem_wr_en_i, ex_wr_en_i};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar t = 0; t < FWD_STAGES; t++) begin : g_stg
      hz_dest_match #(.REG_AW(REG_AW)) u_match (
        .src_i   (src[s]),
        .dst_i   (dst[t]),
        .wr_en_i (wr_en[t]),
        .hit_o   (hit[s][t])
      );
    end
    hz_prio_sel #(.NUM_STAGE(FWD_STAGES), .SEL_W(SEL_W)) u_prio (
      .hit_i (hit[s]),
      .sel_o (sel[s])
    );
  end

  hz_load_stall #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_stall (
    .ex_load_i (ex_load_i),
    .sel_i     (sel),
    .stall_o   (stall_o)
  );

  assign sel_a_o = sel[0];
  assign sel_b_o = sel[1];
endmodule

// File: rtl/fwd_hazard_unit_chk.sv
`timescale 1ns/1ps
module fwd_hazard_unit_chk
  import fwd_hazard_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input logic [REG_AW-1:0] src_a_i,
  input logic [REG_AW-1:0] src_b_i,
  input logic [REG_AW-1:0] ex_dst_i,
  input logic              ex_wr_en_i,
  input logic              ex_load_i,
  input logic [REG_AW-1:0] mem_dst_i,
  input logic              mem_wr_en_i,
  input logic [REG_AW-1:0] wb_dst_i,
  input logic              wb_wr_en_i,
  input logic [SEL_W-1:0]  sel_a_o,
  input logic [SEL_W-1:0]  sel_b_o,
  input logic              stall_o
);
  logic ax, am, aw, bx, bm, bw;
  assign ax = ex_wr_en_i  && src_a_i != '0 && src_a_i == ex_dst_i;
  assign am = mem_wr_en_i && src_a_i != '0 && src_a_i == mem_dst_i;
  assign aw = wb_wr_en_i  && src_a_i != '0 && src_a_i == wb_dst_i;
  assign bx = ex_wr_en_i  && src_b_i != '0 && src_b_i == ex_dst_i;
  assign bm = mem_wr_en_i && src_b_i != '0 && src_b_i == mem_dst_i;
  assign bw = wb_wr_en_i  && src_b_i != '0 && src_b_i == wb_dst_i;

  always_comb begin
    assert_rf_a_R1: assert (sel_a_o != OPND_RF || !(ax || am || aw))
      else $error("operand A chose register file despite a match");
    assert_ex_a_R2: assert (sel_a_o != OPND_EX || ax)
      else $error("operand A chose execute without a match");
    assert_mem_a_R3: assert (sel_a_o != OPND_MEM || (am && !ax))
      else $error("operand A chose memory wrongly");
    assert_wb_a_R4: assert (sel_a_o != OPND_WB || (aw && !ax && !am))
      else $error("operand A chose write-back wrongly");
    assert_near_a_R5: assert (!ax || sel_a_o == OPND_EX)
      else $error("operand A skipped the nearest stage");
    assert_zero_a_R6: assert (src_a_i != '0 || sel_a_o == OPND_RF)
      else $error("register 0 forwarded on A");
    assert_rf_b_R8: assert (sel_b_o != OPND_RF || !(bx || bm || bw))
      else $error("operand B chose register file despite a match");
    assert_fwd_b_R8: assert ((sel_b_o != OPND_EX || bx) &&
                             (sel_b_o != OPND_MEM || (bm && !bx)) &&
                             (sel_b_o != OPND_WB || (bw && !bx && !bm)))
      else $error("operand B select inconsistent with matches");
    assert_zero_b_R6: assert (src_b_i != '0 || sel_b_o == OPND_RF)
      else $error("register 0 forwarded on B");
    assert_stall_R9: assert (stall_o == (ex_load_i &&
                             (sel_a_o == OPND_EX || sel_b_o == OPND_EX)))
      else $error("stall does not follow load-in-execute rule");
  end
endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .src_a_i     (src_a_i),
  .src_b_i     (src_b_i),
  .ex_dst_i    (ex_dst_i),
  .ex_wr_en_i  (ex_wr_en_i),
  .ex_load_i   (ex_load_i),
  .mem_dst_i   (mem_dst_i),
  .mem_wr_en_i (mem_wr_en_i),
  .wb_dst_i    (wb_dst_i),
  .wb_wr_en_i  (wb_wr_en_i),
  .sel_a_o     (sel_a_o),
  .sel_b_o     (sel_b_o),
  .stall_o     (stall_o)
);

// File: tb/fwd_hazard_unit_test.sv
`timescale 1ns/1ps
module fwd_hazard_unit_test;
  typedef struct packed {
    logic [4:0] dst;
    logic [4:0] s1;
    logic [4:0] s2;
    logic       wr;
    logic       ld;
  } instr_t;

  localparam instr_t BUBBLE = '0;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] src_a, src_b, ex_dst, mem_dst, wb_dst;
  logic       ex_wr, ex_ld, mem_wr, wb_wr;
  logic [1:0] sel_a, sel_b;
  logic       stall;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  fwd_hazard_unit #(.REG_AW(5)) uut (
    .src_a_i(src_a), .src_b_i(src_b),
    .ex_dst_i(ex_dst), .ex_wr_en_i(ex_wr), .ex_load_i(ex_ld),
    .mem_dst_i(mem_dst), .mem_wr_en_i(mem_wr),
    .wb_dst_i(wb_dst), .wb_wr_en_i(wb_wr),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .stall_o(stall)
  );

  function automatic int ref_sel(logic [4:0] s, logic [4:0] ed, logic ew,
                                 logic [4:0] md, logic mw, logic [4:0] wd, logic ww);
    if (s == 0) return 0;
    if (ew && s == ed) return 1;
    if (mw && s == md) return 2;
    if (ww && s == wd) return 3;
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [4:0] a, logic [4:0] b,
                       logic [4:0] ed, logic ew, logic el,
                       logic [4:0] md, logic mw, logic [4:0] wd, logic ww);
    @(negedge clk);
    src_a = a; src_b = b; ex_dst = ed; ex_wr = ew; ex_ld = el;
    mem_dst = md; mem_wr = mw; wb_dst = wd; wb_wr = ww;
    #1;
  endtask

  task automatic check_all(string req);
    int ea, eb, es;
    ea = ref_sel(src_a, ex_dst, ex_wr, mem_dst, mem_wr, wb_dst, wb_wr);
    eb = ref_sel(src_b, ex_dst, ex_wr, mem_dst, mem_wr, wb_dst, wb_wr);
    es = (ex_ld && (ea == 1 || eb == 1)) ? 1 : 0;
    chk({req, " sel_a"}, int'(sel_a), ea);
    chk({req, " sel_b"}, int'(sel_b), eb);
    chk({req, " stall"}, int'(stall), es);
  endtask

  // pipeline harness
  instr_t prog [8];
  instr_t id_q, ex_q, mem_q, wb_q;
  int pc;

  task automatic show_stages();
    src_a = id_q.s1; src_b = id_q.s2;
    ex_dst = ex_q.dst; ex_wr = ex_q.wr; ex_ld = ex_q.ld;
    mem_dst = mem_q.dst; mem_wr = mem_q.wr;
    wb_dst = wb_q.dst; wb_wr = wb_q.wr;
  endtask

  task automatic advance();
    logic st;
    st = stall;
    @(posedge clk);
    wb_q  = mem_q;
    mem_q = ex_q;
    ex_q  = st ? BUBBLE : id_q;
    if (!st) begin
      id_q = (pc < 8) ? prog[pc] : BUBBLE;
      pc++;
    end
    show_stages();
    @(negedge clk);
    #1;
  endtask

  initial begin
    int seed;
    int stalls;
    seed = 32'h5eed;
    void'($urandom(seed));
    id_q = BUBBLE; ex_q = BUBBLE; mem_q = BUBBLE; wb_q = BUBBLE; pc = 0;
    show_stages();
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;

    // reset state: empty pipeline
    chk("R1 reset sel_a", int'(sel_a), 0);
    chk("R1 reset sel_b", int'(sel_b), 0);
    chk("R9 reset stall", int'(stall), 0);

    // priority over every write-enable combination, all stages name r7
    for (int m = 0; m < 8; m++) begin
      int e;
      drive(5'd7, 5'd7, 5'd7, m[0], 1'b0, 5'd7, m[1], 5'd7, m[2]);
      e = m[0] ? 1 : m[1] ? 2 : m[2] ? 3 : 0;
      chk("R5 priority sel_a", int'(sel_a), e);
      chk("R8 priority sel_b", int'(sel_b), e);
      chk("R9 no load stall", int'(stall), 0);
    end
    // single-stage hits
    drive(5'd9, 5'd0, 5'd9, 1'b1, 1'b0, 5'd1, 1'b1, 5'd2, 1'b1);
    chk("R2 ex hit", int'(sel_a), 1);
    drive(5'd9, 5'd0, 5'd3, 1'b1, 1'b0, 5'd9, 1'b1, 5'd2, 1'b1);
    chk("R3 mem hit", int'(sel_a), 2);
    drive(5'd9, 5'd0, 5'd3, 1'b1, 1'b0, 5'd4, 1'b1, 5'd9, 1'b1);
    chk("R4 wb hit", int'(sel_a), 3);
    // register zero
    drive(5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1);
    chk("R6 zero sel_a", int'(sel_a), 0);
    chk("R6 zero sel_b", int'(sel_b), 0);
    chk("R6 zero stall", int'(stall), 0);
    // write-enable clear
    drive(5'd12, 5'd12, 5'd12, 1'b0, 1'b1, 5'd12, 1'b0, 5'd12, 1'b0);
    chk("R7 no write sel_a", int'(sel_a), 0);
    chk("R7 no write stall", int'(stall), 0);
    // independence
    drive(5'd5, 5'd6, 5'd5, 1'b1, 1'b0, 5'd1, 1'b0, 5'd6, 1'b1);
    chk("R8 a from ex", int'(sel_a), 1);
    chk("R8 b from wb", int'(sel_b), 3);
    // load stall on B only
    drive(5'd3, 5'd8, 5'd8, 1'b1, 1'b1, 5'd3, 1'b1, 5'd0, 1'b0);
    chk("R9 load stall via b", int'(stall), 1);
    // load already in memory stage
    drive(5'd8, 5'd0, 5'd2, 1'b1, 1'b0, 5'd8, 1'b1, 5'd0, 1'b0);
    chk("R10 load in mem sel", int'(sel_a), 2);
    chk("R10 load in mem stall", int'(stall), 0);

    // constrained random, small register range to provoke matches
    for (int i = 0; i < 3000; i++) begin
      drive(5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4), 1'($urandom),
            1'($urandom), 5'($urandom % 4), 1'($urandom), 5'($urandom % 4),
            1'($urandom));
      check_all("R1-random R9");
    end

    // harness: chained loads then dependent ALU ops
    prog[0] = '{dst:5'd1, s1:5'd0, s2:5'd0, wr:1'b1, ld:1'b1};
    prog[1] = '{dst:5'd2, s1:5'd1, s2:5'd0, wr:1'b1, ld:1'b1};
    prog[2] = '{dst:5'd3, s1:5'd2, s2:5'd1, wr:1'b1, ld:1'b0};
    prog[3] = '{dst:5'd4, s1:5'd3, s2:5'd2, wr:1'b1, ld:1'b0};
    for (int k = 4; k < 8; k++) prog[k] = BUBBLE;
    id_q = BUBBLE; ex_q = BUBBLE; mem_q = BUBBLE; wb_q = BUBBLE; pc = 0;
    @(negedge clk); show_stages(); #1;

    advance();                                   // decode: first load
    chk("R12 first load no stall", int'(stall), 0);
    advance();                                   // second load behind first
    chk("R12 load-use sel_a", int'(sel_a), 1);
    chk("R12 load-use stall", int'(stall), 1);
    advance();                                   // bubble in execute
    chk("R11 after bubble sel_a", int'(sel_a), 2);
    chk("R11 after bubble stall", int'(stall), 0);
    advance();                                   // add behind second load
    chk("R12 second stall", int'(stall), 1);
    chk("R12 add sel_a", int'(sel_a), 1);
    chk("R12 add sel_b from wb", int'(sel_b), 3);
    advance();
    chk("R11 add after bubble sel_a", int'(sel_a), 2);
    chk("R12 bubble no match sel_b", int'(sel_b), 0);
    chk("R11 add after bubble stall", int'(stall), 0);
    advance();                                   // sub behind add
    chk("R10 alu in ex sel_a", int'(sel_a), 1);
    chk("R10 alu in ex stall", int'(stall), 0);
    chk("R12 sub sel_b from wb", int'(sel_b), 3);

    stalls = 0;
    for (int k = 0; k < 4; k++) begin
      if (stall) stalls++;
      advance();
    end
    chk("R12 drain no stall", stalls, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule